// File: doc/BRIEF.md
# External Bus Wait-State Controller

This block stands between a processor core and an external memory and I/O bus. It stretches every external access by a number of wait states. The wait count is programmed separately for program space, data space and I/O space. Once the programmed waits have run out, a slow device can add more waits by holding the bus ready input low. The block also tells internal accesses apart from external ones. Internal accesses complete in a single cycle and do not touch the bus.

The core hands in one request at a time on a valid/ready interface. A request is taken on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while no access is in flight, so a request that arrives during an access is held back until that access has ended. The address, write data and strobes are latched when the request is taken and stay stable on the bus for the whole access. The core sees `core_stall` during the stretched cycles and a one-cycle `core_done` in the final cycle of the access. For a read, `core_rdata` is valid in that final cycle.

A 9-bit wait configuration register sits at I/O address FFFFh and is both written and read through I/O space.

Top module: `xbus_wait_ctrl`

## Requirements
- R1: After reset, every wait field holds 7. A read of I/O address FFFFh returns the register zero-extended, so it reads 0x01FF. The field for program space is in bits [2:0], data space in [5:3] and I/O space in [8:6]. Space codes are 0 for program, 1 for data, 2 for I/O, and 3 is treated as I/O.
- R2: An external read in a space whose wait field is W takes W+1 cycles. The cycles are counted from the first cycle after acceptance up to and including the cycle in which `core_done` is high. This holds when `bus_ready` is high.
- R3: When W ≥ 1, `bus_ready` is sampled only after the W wait cycles. Each cycle in which it is sampled low adds exactly one cycle to the access.
- R4: When W = 0, `bus_ready` is never sampled, and an external read completes in one cycle even when ready is low.
- R5: An external write takes at least two cycles. A write with W = 0 takes exactly two cycles, and `bus_ready` is ignored for that write.
- R6: Program and data addresses below 0x0800 are internal, and so is I/O address FFFFh. Internal accesses complete in one cycle, ignore `bus_ready` and never raise `bus_rd` or `bus_wr`.
- R7: A write to I/O address FFFFh loads bits [8:0] of the write data into the wait configuration register. The new values apply from the next access.
- R8: `core_stall` is high in every cycle of an access except the last. `core_done` is high only in the last cycle. The two are never high together.
- R9: During an external access, `bus_addr`, `bus_wdata` and `bus_space` hold the values of the accepted request. `bus_rd` is high in every cycle of a read. `bus_wr` is high in every cycle of a write except the final one.
- R10: `req_ready` is low from acceptance through the done cycle. Requests presented during that time are not taken, and they do not change the bus outputs.
- R11: In the done cycle of a read, `core_rdata` carries `bus_rdata` for an external access. It carries the register value for a read of FFFFh, and zero for other internal reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Core presents an access |
| req_ready | output | 1 | Controller can take an access this cycle |
| req_space | input | 2 | Space code: 0 program, 1 data, 2 or 3 I/O |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 16 | Access address |
| req_wdata | input | 16 | Write data |
| core_stall | output | 1 | Access in flight, core must wait |
| core_done | output | 1 | Last cycle of the access |
| core_rdata | output | 16 | Read data, valid with core_done on reads |
| bus_addr | output | 16 | External address |
| bus_wdata | output | 16 | External write data |
| bus_rdata | input | 16 | External read data |
| bus_ready | input | 1 | External ready, low to add waits |
| bus_rd | output | 1 | External read strobe |
| bus_wr | output | 1 | External write strobe |
| bus_space | output | 2 | Space code of the external access |
| int_sel | output | 1 | Internal access in flight |

## Verification
The assertions assume two things about the inputs: the core keeps at most one access in flight, and it treats `req_ready` as the only permission to start one. They also assume `bus_ready` is driven to a known level every cycle. The bench drives all stimulus half a clock away from the sampling edge and chooses `bus_ready` per cycle from a planned count of low cycles. During every access it keeps `req_valid` high with a changed address, which exercises the hold-off without ever breaking the single-access rule.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  localparam int WS_W       = 3;
  localparam int NUM_SPACES = 3;
  localparam int CFG_W      = WS_W * NUM_SPACES;

  typedef enum logic [1:0] {
    SP_PROG = 2'd0,
    SP_DATA = 2'd1,
    SP_IO   = 2'd2,
    SP_IO2  = 2'd3
  } space_e;
endpackage

// File: rtl/xbus_wait_cfg.sv
module xbus_wait_cfg #(
  parameter int FW  = 3,
  parameter int NSP = 3,
  localparam int CW = FW * NSP
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [CW-1:0] wr_data,
  output logic [CW-1:0] cfg_q
);
  // Each field resets to its maximum, the slowest and safest setting.
  for (genvar g = 0; g < NSP; g++) begin : g_field
    logic [FW-1:0] fld;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     fld <= '1;
      else if (wr_en) fld <= wr_data[g*FW +: FW];
    end
    assign cfg_q[g*FW +: FW] = fld;
  end
endmodule

// File: rtl/xbus_addr_decode.sv
module xbus_addr_decode #(
  parameter int          AW        = 16,
  parameter logic [15:0] INT_LIMIT = 16'h0800,
  parameter logic [15:0] CFG_ADDR  = 16'hFFFF
) (
  input  logic [1:0]    space,
  input  logic [AW-1:0] addr,
  output logic          is_int,
  output logic          is_cfg,
  output logic [1:0]    fld_idx
);
  import xbus_pkg::*;
  logic is_io;

  always_comb begin
    is_io   = (space == SP_IO) || (space == SP_IO2);
    is_cfg  = is_io && (addr == AW'(CFG_ADDR));
    is_int  = is_cfg || (!is_io && (addr < AW'(INT_LIMIT)));
    fld_idx = is_io ? 2'd2 : space;
  end
endmodule

// File: rtl/xbus_wait_timer.sv
module xbus_wait_timer #(
  parameter int FW = 3,
  localparam int CNT_W = FW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [FW-1:0] prog_waits,
  input  logic          is_write,
  input  logic          bypass,
  input  logic          bus_ready,
  output logic          busy,
  output logic          last
);
  logic [CNT_W-1:0] cnt_q, ld_cnt;
  logic             honour_q, ld_honour;

  always_comb begin
    if (bypass) begin
      ld_cnt    = '0;
      ld_honour = 1'b0;
    end else begin
      // Writes get one forced wait when none is programmed.
      ld_cnt    = (is_write && prog_waits == '0) ? CNT_W'(1) : CNT_W'(prog_waits);
      ld_honour = (prog_waits != '0);
    end
  end

  assign last = busy && (cnt_q == '0) && (!honour_q || bus_ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      cnt_q    <= '0;
      honour_q <= 1'b0;
    end else if (start) begin
      busy     <= 1'b1;
      cnt_q    <= ld_cnt;
      honour_q <= ld_honour;
    end else if (busy) begin
      if (cnt_q != '0) cnt_q <= cnt_q - CNT_W'(1);
      else if (last)   busy  <= 1'b0;
    end
  end
endmodule

// File: rtl/xbus_wait_ctrl.sv
module xbus_wait_ctrl #(
  parameter int          AW        = 16,
  parameter int          DW        = 16,
  parameter logic [15:0] INT_LIMIT = 16'h0800,
  parameter logic [15:0] CFG_ADDR  = 16'hFFFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_space,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          core_stall,
  output logic          core_done,
  output logic [DW-1:0] core_rdata,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  input  logic          bus_ready,
  output logic          bus_rd,
  output logic          bus_wr,
  output logic [1:0]    bus_space,
  output logic          int_sel
);
  import xbus_pkg::*;

  logic          accept, busy, last;
  logic          dec_int, dec_cfg;
  logic [1:0]    dec_idx;
  logic [CFG_W-1:0] cfg_q;
  logic [WS_W-1:0]  prog_waits;

  logic          a_write, a_int, a_cfg;
  logic [AW-1:0] a_addr;
  logic [DW-1:0] a_wdata;
  logic [1:0]    a_space;

  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;

  xbus_addr_decode #(.AW(AW), .INT_LIMIT(INT_LIMIT), .CFG_ADDR(CFG_ADDR)) u_dec (
    .space(req_space), .addr(req_addr),
    .is_int(dec_int), .is_cfg(dec_cfg), .fld_idx(dec_idx)
  );

  assign prog_waits = cfg_q[dec_idx*WS_W +: WS_W];

  xbus_wait_timer #(.FW(WS_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(accept), .prog_waits(prog_waits),
    .is_write(req_write), .bypass(dec_int), .bus_ready(bus_ready),
    .busy(busy), .last(last)
  );

  xbus_wait_cfg #(.FW(WS_W), .NSP(NUM_SPACES)) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .wr_en(last && a_cfg && a_write),
    .wr_data(a_wdata[CFG_W-1:0]),
    .cfg_q(cfg_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_write <= 1'b0;
      a_int   <= 1'b0;
      a_cfg   <= 1'b0;
      a_addr  <= '0;
      a_wdata <= '0;
      a_space <= '0;
    end else if (accept) begin
      a_write <= req_write;
      a_int   <= dec_int;
      a_cfg   <= dec_cfg;
      a_addr  <= req_addr;
      a_wdata <= req_wdata;
      a_space <= req_space;
    end
  end

  always_comb begin
    core_done  = last;
    core_stall = busy && !last;
    int_sel    = busy && a_int;
    bus_addr   = a_addr;
    bus_wdata  = a_wdata;
    bus_space  = a_space;
    bus_rd     = busy && !a_int && !a_write;
    bus_wr     = busy && !a_int && a_write && !last;
    core_rdata = '0;
    if (last && !a_write) begin
      if (a_cfg)       core_rdata = DW'(cfg_q);
      else if (!a_int) core_rdata = bus_rdata;
    end
  end
endmodule

// File: rtl/xbus_wait_ctrl_chk.sv
module xbus_wait_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic       req_write,
  input logic       core_stall,
  input logic       core_done,
  input logic       bus_rd,
  input logic       bus_wr,
  input logic       int_sel,
  input logic [15:0] bus_addr,
  input logic [15:0] bus_wdata
);
  p_stall_done_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(core_stall && core_done));

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    core_done |=> !core_done);

  p_no_accept_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (core_stall || core_done) |-> !req_ready);

  p_hold_bus_r9: assert property (@(posedge clk) disable iff (!rst_n)
    core_stall |=> ($stable(bus_addr) && $stable(bus_wdata)));

  p_wr_final_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    core_done |-> !bus_wr);

  p_int_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    int_sel |-> (!bus_rd && !bus_wr));

  p_write_two_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_write) |=> (int_sel || !core_done));

  p_strobe_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bus_rd, bus_wr}));
endmodule

bind xbus_wait_ctrl xbus_wait_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .core_stall(core_stall), .core_done(core_done),
  .bus_rd(bus_rd), .bus_wr(bus_wr), .int_sel(int_sel),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata)
);

// File: tb/xbus_wait_ctrl_tb.sv
module xbus_wait_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, bus_ready = 1'b1;
  logic [1:0]  req_space = '0;
  logic [15:0] req_addr = '0, req_wdata = '0, bus_rdata = '0;
  logic        req_ready, core_stall, core_done, bus_rd, bus_wr, int_sel;
  logic [15:0] core_rdata, bus_addr, bus_wdata;
  logic [1:0]  bus_space;

  int checks = 0, fails = 0, cycles = 0;
  logic [8:0] cfg_m = 9'h1FF;

  xbus_wait_ctrl u_dut (.*);

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      finish_run();
    end
  end

  function automatic bit is_internal(input logic [1:0] sp, input logic [15:0] a);
    if (sp >= 2) return a == 16'hFFFF;
    return a < 16'h0800;
  endfunction

  function automatic int exp_len(input logic [1:0] sp, input logic [15:0] a,
                                 input bit wr, input int lows);
    int w, weff, t;
    if (is_internal(sp, a)) return 1;
    w = int'(cfg_m[(sp >= 2 ? 2 : int'(sp))*3 +: 3]);
    weff = (wr && w == 0) ? 1 : w;
    t = weff + 1;
    if (w != 0 && lows + 1 > t) t = lows + 1;
    return t;
  endfunction

  // One access; ready is held low for the first 'lows' cycles of the access.
  task automatic access(input logic [1:0] sp, input bit wr, input logic [15:0] a,
                        input logic [15:0] wd, input int lows, input string tag);
    int t_exp, k;
    bit ext, hs_ok, bus_ok, done_seen;
    logic [15:0] rd_exp, rd_got;
    t_exp = exp_len(sp, a, wr, lows);
    ext = !is_internal(sp, a);
    @(negedge clk);
    chk(req_ready == 1'b1, {tag, " R10 idle ready"}, req_ready, 1);
    req_valid = 1'b1; req_space = sp; req_write = wr; req_addr = a; req_wdata = wd;
    bus_rdata = 16'($urandom);
    @(posedge clk);
    hs_ok = 1'b1; bus_ok = 1'b1; done_seen = 1'b0; k = 0; rd_got = '0;
    while (!done_seen && k < 40) begin
      k++;
      @(negedge clk);
      bus_ready = (k > lows);
      req_addr = ~a;
      #1;
      if (req_ready) hs_ok = 1'b0;
      if (core_done) begin
        done_seen = 1'b1;
        rd_got = core_rdata;
        if (core_stall) hs_ok = 1'b0;
      end else if (!core_stall) hs_ok = 1'b0;
      if (ext) begin
        if (bus_addr != a || bus_space != sp || (wr && bus_wdata != wd)) bus_ok = 1'b0;
        if (bus_rd != !wr) bus_ok = 1'b0;
        if (bus_wr != (wr && !core_done)) bus_ok = 1'b0;
      end else if (bus_rd || bus_wr) bus_ok = 1'b0;
      if (done_seen) req_valid = 1'b0;
    end
    req_valid = 1'b0;
    bus_ready = 1'b1;
    chk(k == t_exp, {tag, " R2/R3/R4/R5/R6 length"}, k, t_exp);
    chk(hs_ok, {tag, " R8 R10 handshake"}, hs_ok, 1);
    chk(bus_ok, {tag, " R9 R6 bus strobes"}, bus_ok, 1);
    if (!wr) begin
      if (!ext && sp >= 2) rd_exp = {7'd0, cfg_m};
      else if (!ext) rd_exp = '0;
      else rd_exp = bus_rdata;
      chk(rd_got == rd_exp, {tag, " R11 read data"}, rd_got, rd_exp);
    end
    if (wr && sp >= 2 && a == 16'hFFFF) cfg_m = wd[8:0];
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    #1;
    chk(core_stall == 0 && core_done == 0 && bus_rd == 0 && bus_wr == 0,
        "R8 reset quiet", {core_stall, core_done, bus_rd, bus_wr}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(req_ready == 1'b1, "R10 ready after reset", req_ready, 1);

    // R1: reset value read back, R2 with default seven waits
    access(2, 0, 16'hFFFF, 0, 0, "R1 cfg reset read");
    chk(cfg_m == 9'h1FF, "R1 model", cfg_m, 9'h1FF);
    access(0, 0, 16'h1234, 0, 0, "R2 prog default");
    access(1, 0, 16'h9000, 0, 0, "R2 data default");
    access(2, 0, 16'h0040, 0, 0, "R2 io default");
    // R7: program distinct waits per space (prog 0, data 2, io 5)
    access(2, 1, 16'hFFFF, 16'hFE00 | 16'((5 << 6) | (2 << 3) | 0), 0, "R7 cfg write");
    access(2, 0, 16'hFFFF, 0, 0, "R7 cfg readback");
    access(0, 0, 16'h4000, 0, 3, "R4 ready ignored W0");
    access(0, 1, 16'h4000, 16'hA5A5, 4, "R5 write W0 two cycles");
    access(1, 0, 16'h2000, 0, 0, "R2 data W2");
    access(1, 0, 16'h2000, 0, 6, "R3 ready stretch");
    access(1, 0, 16'h2000, 0, 2, "R3 ready low inside waits");
    access(2, 1, 16'h0010, 16'h1111, 9, "R3 io write stretch");
    access(3, 0, 16'h0020, 0, 0, "R1 space3 as io");
    access(0, 0, 16'h0100, 0, 5, "R6 internal prog");
    access(1, 1, 16'h07FF, 16'h2222, 5, "R6 internal data edge");
    access(1, 0, 16'h0800, 0, 0, "R6 first external data");

    for (int i = 0; i < 300; i++) begin
      logic [1:0] sp; logic [15:0] a; bit wr; int lows;
      sp = 2'($urandom_range(0, 2));
      wr = 1'($urandom);
      case ($urandom_range(0, 3))
        0: a = 16'($urandom_range(0, 16'h07FF));
        1: a = 16'hFFFF;
        default: a = 16'($urandom_range(16'h0800, 16'hFFFE));
      endcase
      lows = $urandom_range(0, 3) == 0 ? $urandom_range(0, 10) : 0;
      access(sp, wr, a, 16'($urandom), lows, "random");
    end
    finish_run();
  end
endmodule